// File: doc/BRIEF.md
# Ping-Pong Frame Store with Two Serial Readers

The block keeps one position frame from an encoder in two alternating banks. The frame master writes the bits of a frame one at a time into the write bank, and each bit carries its own position. When the master ends the frame with a commit, the write bank becomes the read bank, but only if no error was flagged during that frame. Any frame that saw an error is dropped, and the last good frame stays readable.

Two read ports share the readable frame: one serves a data logger and one serves a motor drive. Each port has a level request and a read clock driven from outside, and it gives back a serial data bit and a done flag. The read clocks are asynchronous to the system clock, so each is resampled and edge-detected inside the block. A read shifts the stored frame out from bit 0, one bit for each read-clock rise, and then signals done.

A bank swap never happens while a port is partway through a frame. A commit that arrives in that window is held until both readers are idle. Each request produces exactly one readout, and each commit produces at most one swap, however long the request or commit level is held.

Top module: `frame_pingpong_store`

## Requirements
- R1: After reset both done outputs and both serial outputs are 0, and no valid frame is held.
- R2: On a cycle with `wr_en` high, `wr_bit` is stored at position `wr_idx` of the write bank. Bits may be written in any order.
- R3: A rising `wr_commit` with no error since the previous commit swaps the banks. The swap happens on the first cycle in which neither port is shifting, and from then on the committed frame is what the ports read.
- R4: If `wr_err` is high on any cycle since the previous commit, or on the commit cycle itself, the commit is discarded: no swap happens and the last good frame stays readable.
- R5: A commit level held high commits once. Frames written while it stays high are not committed.
- R6: When a request rises, the port's serial output shows bit 0. Each detected rising edge of its read clock advances the output to the next bit. After FRAME_BITS edges, done goes to 1 and the serial output goes to 0.
- R7: Done stays at 1 while the request is held and clears on the cycle after the request falls. Further read-clock edges during a held request start no new readout.
- R8: The two ports run independently, with separate requests and read clocks of different rates, and both may read at the same time.
- R9: A swap that falls due while either port is shifting is deferred, so a port returns the whole frame it started with.
- R10: Before the first good frame, a read returns all zeros and still finishes with done.
- R11: While a swap is pending, bit writes, errors and commits are ignored.
- R12: A read-clock rise driven just after a clock edge moves the serial output to the next bit three system-clock edges later (two resampling stages plus the shift register).
- R13: Dropping the request during a readout abandons it. Done stays 0, the output returns to 0, and the next request starts again from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store `wr_bit` this cycle |
| wr_idx | input | IDX_W | Bit position within the frame |
| wr_bit | input | 1 | Frame bit value |
| wr_commit | input | 1 | Frame-complete level; its rising edge commits |
| wr_err | input | 1 | Upstream error flag, vetoes the current frame |
| log_req | input | 1 | Logger read request (level) |
| log_rclk | input | 1 | Logger read clock, asynchronous |
| log_sdo | output | 1 | Logger serial data |
| log_done | output | 1 | Logger readout complete |
| mtr_req | input | 1 | Motor read request (level) |
| mtr_rclk | input | 1 | Motor read clock, asynchronous |
| mtr_sdo | output | 1 | Motor serial data |
| mtr_done | output | 1 | Motor readout complete |

## Verification
The assertions assume that requests and write controls are synchronous to `clk`. They also assume that each read-clock level lasts at least two system cycles, so that every rise is seen exactly once after resampling. The bench drives every control on the falling clock edge and holds each read-clock phase for three cycles or more. The two ports use different phase lengths. Commits and write bursts are timed to fall inside an active readout, which forces the deferred-swap and ignored-write paths.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_SHIFT = 2'd1,
        RD_DONE  = 2'd2
    } rd_state_e;

    localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/ppbuf_edge_sync.sv
module ppbuf_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.sh = {s_q.sh[STAGES-1:0], raw};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
endmodule

// File: rtl/ppbuf_reader.sv
module ppbuf_reader
    import ppbuf_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req,
    input  logic                        rclk_raw,
    input  logic [1:0][FRAME_BITS-1:0]  banks,
    input  logic                        sel_next,
    input  logic                        vld_next,
    output logic                        sdo,
    output logic                        done,
    output logic                        busy
);
    localparam int unsigned IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        rd_state_e        st;
        logic [IDX_W-1:0] ptr;
        logic             sel;
        logic             vld;
    } rd_t;

    rd_t  r_d, r_q;
    logic edge_seen;

    ppbuf_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (rclk_raw),
        .rise (edge_seen)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RD_IDLE: begin
                if (req) begin
                    r_d.st  = RD_SHIFT;
                    r_d.ptr = '0;
                    r_d.sel = sel_next;
                    r_d.vld = vld_next;
                end
            end
            RD_SHIFT: begin
                if (!req) begin
                    r_d.st = RD_IDLE;
                end else if (edge_seen) begin
                    if (r_q.ptr == LAST_IDX) r_d.st  = RD_DONE;
                    else                     r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            RD_DONE: begin
                if (!req) r_d.st = RD_IDLE;
            end
            default: r_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: RD_IDLE, ptr: '0, sel: 1'b0, vld: 1'b0};
        else        r_q <= r_d;
    end

    assign sdo  = (r_q.st == RD_SHIFT && r_q.vld) ? banks[r_q.sel][r_q.ptr] : 1'b0;
    assign done = (r_q.st == RD_DONE);
    assign busy = (r_q.st == RD_SHIFT);

    // R7: done releases one cycle after the request drops
    assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req) |=> !done);
    // R7: a held request keeps done and never restarts the readout
    assert_no_rerun_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> done);
    // R9: the bank a reader follows does not move while it shifts
    assert_sel_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(r_q.sel));
endmodule

// File: rtl/frame_pingpong_store.sv
module frame_pingpong_store
    import ppbuf_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 32,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IDX_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    input  logic             wr_commit,
    input  logic             wr_err,
    input  logic             log_req,
    input  logic             log_rclk,
    output logic             log_sdo,
    output logic             log_done,
    input  logic             mtr_req,
    input  logic             mtr_rclk,
    output logic             mtr_sdo,
    output logic             mtr_done
);
    typedef struct packed {
        logic [1:0][FRAME_BITS-1:0] bank;
        logic                       wsel;
        logic                       valid;
        logic                       pend;
        logic                       bad;
        logic                       wkeep;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_PORTS-1:0] req_v, rclk_v, sdo_v, done_v, busy_v;
    logic                 swap_now;

    assign req_v  = {mtr_req, log_req};
    assign rclk_v = {mtr_rclk, log_rclk};

    assign swap_now = s_q.pend && (busy_v == '0);

    always_comb begin
        s_d       = s_q;
        s_d.wkeep = wr_commit;
        if (!s_q.pend) begin
            if (wr_en)  s_d.bank[s_q.wsel][wr_idx] = wr_bit;
            if (wr_err) s_d.bad = 1'b1;
            if (wr_commit && !s_q.wkeep) begin
                s_d.pend = !(s_q.bad || wr_err);
                s_d.bad  = 1'b0;
            end
        end
        if (swap_now) begin
            s_d.wsel  = ~s_q.wsel;
            s_d.valid = 1'b1;
            s_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ppbuf_reader #(
            .FRAME_BITS (FRAME_BITS),
            .SYNC_STAGES(SYNC_STAGES)
        ) i_reader (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_v[p]),
            .rclk_raw(rclk_v[p]),
            .banks   (s_q.bank),
            .sel_next(~s_d.wsel),
            .vld_next(s_d.valid),
            .sdo     (sdo_v[p]),
            .done    (done_v[p]),
            .busy    (busy_v[p])
        );
    end

    assign log_sdo  = sdo_v[0];
    assign log_done = done_v[0];
    assign mtr_sdo  = sdo_v[1];
    assign mtr_done = done_v[1];

    // R9: no swap while a reader is shifting
    assert_swap_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_v != '0) |=> $stable(s_q.wsel));
    // R4: an erroneous frame never reaches the pending state
    assert_err_veto_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.pend && wr_commit && !s_q.wkeep && (wr_err || s_q.bad)) |=> !s_q.pend);
    // R3: once a good frame exists it stays valid
    assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |=> s_q.valid);
    // R11: storage frozen while a swap is pending
    assert_hold_while_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |=> $stable(s_q.bank));
    // R5: a held commit level cannot raise a second pending swap
    assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wkeep && wr_commit && !s_q.pend) |=> !s_q.pend);
endmodule

// File: tb/test_frame_pingpong_store.sv
module test_frame_pingpong_store;
    localparam int N = 32;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_bit = 1'b0, wr_commit = 1'b0, wr_err = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [1:0]    req = '0, rclk = '0;
    logic          log_sdo, log_done, mtr_sdo, mtr_done;

    int checks = 0, fails = 0, cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    frame_pingpong_store #(.FRAME_BITS(N)) i_frame_pingpong_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bit(wr_bit),
        .wr_commit(wr_commit), .wr_err(wr_err),
        .log_req(req[0]), .log_rclk(rclk[0]), .log_sdo(log_sdo), .log_done(log_done),
        .mtr_req(req[1]), .mtr_rclk(rclk[1]), .mtr_sdo(mtr_sdo), .mtr_done(mtr_done)
    );

    function automatic logic out_sdo(int p);
        return (p == 0) ? log_sdo : mtr_sdo;
    endfunction
    function automatic logic out_done(int p);
        return (p == 0) ? log_done : mtr_done;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [N-1:0] m_bank [2];
    logic [N-1:0] m_snap [2];
    bit m_wsel, m_valid, m_pend, m_bad, m_wkeep;
    int m_st [2];
    int m_ptr [2];
    bit m_svld [2];
    bit m_hist [2][3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bank[0] = '0; m_bank[1] = '0;
            m_wsel = 0; m_valid = 0; m_pend = 0; m_bad = 0; m_wkeep = 0;
            for (int p = 0; p < 2; p++) begin
                m_st[p] = 0; m_ptr[p] = 0; m_svld[p] = 0; m_snap[p] = '0;
                for (int h = 0; h < 3; h++) m_hist[p][h] = 0;
            end
        end else begin
            bit sw;
            sw = m_pend && (m_st[0] != 1) && (m_st[1] != 1);
            if (!m_pend) begin
                if (wr_en) m_bank[m_wsel][wr_idx] = wr_bit;
                if (wr_err) m_bad = 1;
                if (wr_commit && !m_wkeep) begin
                    if (!m_bad) m_pend = 1;
                    m_bad = 0;
                end
            end
            m_wkeep = wr_commit;
            if (sw) begin
                m_wsel = !m_wsel; m_valid = 1; m_pend = 0;
            end
            for (int p = 0; p < 2; p++) begin
                bit e;
                e = m_hist[p][1] && !m_hist[p][2];
                m_hist[p][2] = m_hist[p][1];
                m_hist[p][1] = m_hist[p][0];
                m_hist[p][0] = rclk[p];
                case (m_st[p])
                    0: if (req[p]) begin
                        m_st[p] = 1; m_ptr[p] = 0;
                        m_snap[p] = m_bank[!m_wsel]; m_svld[p] = m_valid;
                    end
                    1: if (!req[p]) m_st[p] = 0;
                       else if (e) begin
                           if (m_ptr[p] == N - 1) m_st[p] = 2;
                           else m_ptr[p]++;
                       end
                    default: if (!req[p]) m_st[p] = 0;
                endcase
            end
        end
    end

    // cycle-by-cycle comparison (R6, R8)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int p = 0; p < 2; p++) begin
                logic es, ed;
                es = (m_st[p] == 1 && m_svld[p]) ? m_snap[p][m_ptr[p]] : 1'b0;
                ed = (m_st[p] == 2);
                chk(out_sdo(p) === es, $sformatf("R6 R8 port %0d sdo vs model", p), 32'(out_sdo(p)), 32'(es));
                chk(out_done(p) === ed, $sformatf("R6 R8 port %0d done vs model", p), 32'(out_done(p)), 32'(ed));
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_frame(input logic [N-1:0] f, input int err_at, input bit reverse);
        for (int i = 0; i < N; i++) begin
            int k;
            k = reverse ? (N - 1 - i) : i;
            @(negedge clk);
            wr_en = 1; wr_idx = IW'(k); wr_bit = f[k]; wr_err = (i == err_at);
        end
        @(negedge clk);
        wr_en = 0; wr_err = 0;
    endtask

    task automatic commit_pulse(input bit with_err);
        @(negedge clk); wr_commit = 1; wr_err = with_err;
        @(negedge clk); wr_commit = 0; wr_err = 0;
    endtask

    task automatic rpulse(input int p, input int w);
        rclk[p] = 1; tick(w);
        rclk[p] = 0; tick(w);
    endtask

    task automatic read_port(input int p, input logic [N-1:0] exp, input int w, input string tag);
        logic [N-1:0] got;
        @(negedge clk); req[p] = 1;
        tick(2);
        for (int k = 0; k < N; k++) begin
            got[k] = out_sdo(p);
            chk(!out_done(p), {tag, " done low during shift R6"}, 32'(out_done(p)), 0);
            rpulse(p, w);
        end
        chk(got === exp, {tag, " frame contents"}, got, exp);
        chk(out_done(p) === 1'b1, "R6 done after last bit", 32'(out_done(p)), 1);
        chk(out_sdo(p) === 1'b0, "R6 sdo zero when done", 32'(out_sdo(p)), 0);
        rpulse(p, w); rpulse(p, w);
        chk(out_done(p) === 1'b1 && out_sdo(p) === 1'b0, "R7 held request no rerun",
            {out_done(p), out_sdo(p)}, 32'h2);
        @(negedge clk); req[p] = 0;
        tick(2);
        chk(out_done(p) === 1'b0, "R7 done clears after request falls", 32'(out_done(p)), 0);
    endtask

    localparam logic [N-1:0] FA = 32'hA5C3_1F07;
    localparam logic [N-1:0] FB = 32'h0F0F_F0F0;
    localparam logic [N-1:0] FC = 32'h3C96_5AA1;
    localparam logic [N-1:0] FD = 32'hFFFF_0000;
    localparam logic [N-1:0] FE = 32'h6B2D_91E5;
    localparam logic [N-1:0] FF = 32'h1234_5678;

    initial begin
        tick(5);
        chk(log_done === 0 && mtr_done === 0 && log_sdo === 0 && mtr_sdo === 0,
            "R1 outputs in reset", {log_done, mtr_done, log_sdo, mtr_sdo}, 0);
        @(negedge clk); rst_n = 1;
        tick(2);
        chk(log_done === 0 && mtr_done === 0, "R1 done low after reset", {log_done, mtr_done}, 0);

        // R10: read before any good frame
        read_port(0, '0, 3, "R10 empty read");

        // R2, R3: good frame, readable afterwards
        write_frame(FA, -1, 0);
        commit_pulse(0);
        tick(3);
        read_port(0, FA, 3, "R3 committed frame");

        // R4: error inside the frame, then error on the commit cycle
        write_frame(FB, 10, 0);
        commit_pulse(0);
        tick(3);
        read_port(1, FA, 4, "R4 error mid-frame");
        write_frame(FB, -1, 0);
        commit_pulse(1);
        tick(3);
        read_port(0, FA, 3, "R4 error at commit");

        // R5 with R2: reverse-order write, commit held across a second frame
        write_frame(FC, -1, 1);
        @(negedge clk); wr_commit = 1;
        tick(4);
        write_frame(FD, -1, 0);
        tick(3);
        read_port(1, FC, 3, "R5 held commit R2 reverse order");
        @(negedge clk); wr_commit = 0;
        tick(2);
        read_port(0, FC, 3, "R5 still first frame");

        // R9, R11: swap deferred while motor port shifts
        fork
            read_port(1, FC, 5, "R9 reader keeps its frame");
            begin
                tick(10);
                write_frame(FE, -1, 0);
                commit_pulse(0);
                write_frame(FF, 7, 0);
                commit_pulse(0);
            end
        join
        tick(3);

        // R8: both ports concurrently, different rates
        fork
            read_port(0, FE, 3, "R8 logger concurrent R11 writes ignored");
            read_port(1, FE, 7, "R8 motor concurrent");
        join

        // R12 latency and R13 abort
        @(negedge clk); req[0] = 1;
        tick(2);
        chk(log_sdo === FE[0], "R12 bit0 before edge", 32'(log_sdo), 32'(FE[0]));
        rclk[0] = 1;
        tick(2);
        chk(log_sdo === FE[0], "R12 still bit0 two cycles after rise", 32'(log_sdo), 32'(FE[0]));
        tick(1);
        chk(log_sdo === FE[1], "R12 bit1 three cycles after rise", 32'(log_sdo), 32'(FE[1]));
        rclk[0] = 0; tick(3);
        for (int i = 0; i < 4; i++) rpulse(0, 3);
        req[0] = 0;
        tick(3);
        chk(log_done === 0 && log_sdo === 0, "R13 abandoned read idle", {log_done, log_sdo}, 0);
        read_port(0, FE, 3, "R13 restart from bit0");

        tick(5);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule